// File: doc/BRIEF.md
# Multi-Channel Interrupt Priority Requester

This block collects interrupt requests from four serial channels and turns them into one bus interrupt. Each channel has three request sources: receive, transmit and line status. Every source has its own enable bit. All sources share one interrupt level, which three strap inputs select. Strap value 0 means the block never requests.

A master answers with an acknowledge cycle that carries a level code. On that cycle the block picks a winner among the pending sources by fixed priority. It then returns an 8-bit vector and asserts its acknowledge. The upper nibble of the vector is a programmable base. The lower nibble is a code for the winning source.

A receive request yields one of two codes. The choice depends on whether the character at the head of that channel's receive queue carries any of four special conditions.

If the acknowledged level is not the strapped level, or nothing is pending, the block does not answer. It passes the daisy-chain input through to the daisy-chain output. The block never clears a request itself; each source withdraws its request when it is serviced.

Top module: `irq_priority_requester`

## Requirements
- R1: After reset, `irqLines`, `ackOut`, `vectorOut` and `chainOut` are all zero, and the vector base is 0.
- R2: When at least one enabled source is pending and `levelStrap` = L (1 to 7), `irqLines` bit L-1 is 1 one cycle later and every other bit is 0. With L = 0, or with nothing pending, `irqLines` is 0.
- R3: A source whose enable bit is 0 neither raises `irqLines` nor wins arbitration. Enable bit ch*3+0 gates receive, ch*3+1 gates transmit and ch*3+2 gates status.
- R4: Lower channel numbers win over higher ones. Within a channel, receive beats transmit, which beats status.
- R5: The vector low nibble is a source code:
  - receive with any of the channel's four `rxCond` bits (ch*4 to ch*4+3) set: ch*4+0
  - receive with none of those bits set: ch*4+1
  - transmit: ch*4+2
  - status: ch*4+3
  The upper nibble is the vector base.
- R6: The winner is decided from the inputs at the clock edge where `iack` is first seen high. Later changes to requests do not alter `vectorOut` while `iack` stays high.
- R7: If `iack` rises while `ackLevel` equals a non-zero `levelStrap` and an enabled source is pending, `ackOut` and `vectorOut` are valid from the next cycle. They hold while `iack` stays high, `chainOut` stays 0 during that time, and both `ackOut` and `vectorOut` return to 0 one cycle after `iack` falls.
- R8: If `iack` rises with a level mismatch, or with nothing pending, `ackOut` stays 0. While `iack` stays high, `chainOut` equals `chainIn` delayed by one cycle.
- R9: An acknowledge does not clear any request: `irqLines` stays asserted during and after the acknowledge while the sources remain pending.
- R10: When `baseWe` is 1, `baseData` loads the vector base at that clock edge. Otherwise the base holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxReq | input | 4 | Receive request, one per channel |
| rxCond | input | 16 | Four special-condition flags per channel for the head receive character |
| txReq | input | 4 | Transmit request, one per channel |
| statReq | input | 4 | Status request, one per channel |
| srcEn | input | 12 | Per-source enables, three per channel |
| levelStrap | input | 3 | Strapped request level, 0 disables |
| baseWe | input | 1 | Vector base write strobe |
| baseData | input | 4 | Vector base value |
| iack | input | 1 | Acknowledge cycle in progress |
| ackLevel | input | 3 | Level being acknowledged |
| chainIn | input | 1 | Daisy-chain input |
| irqLines | output | 7 | Interrupt request lines, bit L-1 for level L |
| vectorOut | output | 8 | Vector returned on an answered acknowledge |
| ackOut | output | 1 | Acknowledge response |
| chainOut | output | 1 | Daisy-chain output |

## Verification
The assertions check several properties on every cycle:
- at most one request line is ever active, and only after a pending source existed;
- a vector is latched only when something is pending;
- the acknowledge appears only after `iack` with a matching level;
- the chain output follows the chain input;
- the base register changes only on a write.

Other behaviour can be shown only by the bench's scenarios, which compute the expected results from the inputs:
- the correct winner under mixed priorities and enables;
- the choice between the two receive codes;
- the vector staying frozen against requests that change mid-cycle;
- requests surviving an acknowledge.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;
  typedef struct packed {
    logic latchVec;
    logic clearVec;
  } ackStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_PASS  = 2'd2
  } ackState_t;
endpackage

// File: rtl/irq_pend_datapath.sv
module irq_pend_datapath
  import irq_req_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int COND_W  = 4,
  parameter int LEVEL_W = 3,
  parameter int BASE_W  = 4,
  localparam int NCODE  = NUM_CH * 4,
  localparam int CODE_W = $clog2(NCODE),
  localparam int NLEV   = (1 << LEVEL_W) - 1,
  localparam int VEC_W  = BASE_W + CODE_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        rxReq,
  input  logic [NUM_CH*COND_W-1:0] rxCond,
  input  logic [NUM_CH-1:0]        txReq,
  input  logic [NUM_CH-1:0]        statReq,
  input  logic [NUM_CH*3-1:0]      srcEn,
  input  logic [LEVEL_W-1:0]       levelStrap,
  input  logic                     baseWe,
  input  logic [BASE_W-1:0]        baseData,
  input  ackStrobe_t               strobe,
  output logic                     anyPending,
  output logic [NLEV-1:0]          irqLines,
  output logic [VEC_W-1:0]         vectorOut
);
  logic [NCODE-1:0]  pendCode;
  logic [CODE_W-1:0] winCode;
  logic [NLEV-1:0]   irqNext;
  logic [BASE_W-1:0] baseQ;
  logic [VEC_W-1:0]  vecQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic special;
    assign special = |rxCond[ch*COND_W +: COND_W];
    assign pendCode[ch*4+0] = rxReq[ch] & srcEn[ch*3+0] & special;
    assign pendCode[ch*4+1] = rxReq[ch] & srcEn[ch*3+0] & ~special;
    assign pendCode[ch*4+2] = txReq[ch] & srcEn[ch*3+1];
    assign pendCode[ch*4+3] = statReq[ch] & srcEn[ch*3+2];
  end

  assign anyPending = |pendCode;

  always_comb begin
    winCode = '0;
    for (int i = NCODE - 1; i >= 0; i--) begin
      if (pendCode[i]) winCode = CODE_W'(i);
    end
  end

  for (genvar lv = 1; lv <= NLEV; lv++) begin : g_level
    assign irqNext[lv-1] = anyPending && (levelStrap == LEVEL_W'(lv));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqLines <= '0;
      baseQ    <= '0;
      vecQ     <= '0;
    end else begin
      irqLines <= irqNext;
      if (baseWe) baseQ <= baseData;
      if (strobe.latchVec)      vecQ <= {baseQ, winCode};
      else if (strobe.clearVec) vecQ <= '0;
    end
  end

  assign vectorOut = vecQ;

  assert_one_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqLines));
  assert_irq_has_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|irqLines) |-> $past(anyPending));
  assert_latch_needs_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchVec |-> anyPending);
  assert_base_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    !baseWe |=> $stable(baseQ));
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_req_pkg::*;
#(
  parameter int LEVEL_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               iack,
  input  logic [LEVEL_W-1:0] ackLevel,
  input  logic [LEVEL_W-1:0] levelStrap,
  input  logic               anyPending,
  input  logic               chainIn,
  output ackStrobe_t         strobe,
  output logic               ackOut,
  output logic               chainOut
);
  ackState_t state, stateNext;
  logic levelMatch;

  assign levelMatch = (levelStrap != '0) && (ackLevel == levelStrap);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (iack) begin
          if (levelMatch && anyPending) begin
            stateNext       = ST_GRANT;
            strobe.latchVec = 1'b1;
          end else begin
            stateNext = ST_PASS;
          end
        end
      end
      ST_GRANT: begin
        if (!iack) begin
          stateNext       = ST_IDLE;
          strobe.clearVec = 1'b1;
        end
      end
      ST_PASS: begin
        if (!iack) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      chainOut <= 1'b0;
    end else begin
      state    <= stateNext;
      chainOut <= (stateNext == ST_PASS) ? chainIn : 1'b0;
    end
  end

  assign ackOut = (state == ST_GRANT);

  assert_ack_after_iack_R7: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> $past(iack));
  assert_ack_needs_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOut) |-> $past(anyPending && ackLevel == levelStrap));
  assert_chain_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    chainOut |-> ($past(chainIn) && !ackOut));
endmodule

// File: rtl/irq_priority_requester.sv
module irq_priority_requester
  import irq_req_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int COND_W  = 4,
  parameter int LEVEL_W = 3,
  parameter int BASE_W  = 4,
  localparam int CODE_W = $clog2(NUM_CH * 4),
  localparam int NLEV   = (1 << LEVEL_W) - 1,
  localparam int VEC_W  = BASE_W + CODE_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        rxReq,
  input  logic [NUM_CH*COND_W-1:0] rxCond,
  input  logic [NUM_CH-1:0]        txReq,
  input  logic [NUM_CH-1:0]        statReq,
  input  logic [NUM_CH*3-1:0]      srcEn,
  input  logic [LEVEL_W-1:0]       levelStrap,
  input  logic                     baseWe,
  input  logic [BASE_W-1:0]        baseData,
  input  logic                     iack,
  input  logic [LEVEL_W-1:0]       ackLevel,
  input  logic                     chainIn,
  output logic [NLEV-1:0]          irqLines,
  output logic [VEC_W-1:0]         vectorOut,
  output logic                     ackOut,
  output logic                     chainOut
);
  ackStrobe_t strobe;
  logic       anyPending;

  irq_pend_datapath #(
    .NUM_CH(NUM_CH), .COND_W(COND_W), .LEVEL_W(LEVEL_W), .BASE_W(BASE_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .rxReq(rxReq), .rxCond(rxCond), .txReq(txReq),
    .statReq(statReq), .srcEn(srcEn), .levelStrap(levelStrap),
    .baseWe(baseWe), .baseData(baseData), .strobe(strobe),
    .anyPending(anyPending), .irqLines(irqLines), .vectorOut(vectorOut)
  );

  irq_ack_ctrl #(.LEVEL_W(LEVEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .iack(iack), .ackLevel(ackLevel),
    .levelStrap(levelStrap), .anyPending(anyPending), .chainIn(chainIn),
    .strobe(strobe), .ackOut(ackOut), .chainOut(chainOut)
  );
endmodule

// File: tb/irq_priority_requester_bench.sv
module irq_priority_requester_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rxReq = '0, txReq = '0, statReq = '0;
  logic [15:0] rxCond = '0;
  logic [11:0] srcEn = '0;
  logic [2:0]  levelStrap = '0, ackLevel = '0;
  logic        baseWe = 1'b0, iack = 1'b0, chainIn = 1'b0;
  logic [3:0]  baseData = '0;
  logic [6:0]  irqLines;
  logic [7:0]  vectorOut;
  logic        ackOut, chainOut;

  int testCount = 0;
  int failCount = 0;
  logic [3:0] modelBase = '0;

  always #4 clk = ~clk;

  irq_priority_requester u_irq_priority_requester (
    .clk(clk), .rstN(rstN), .rxReq(rxReq), .rxCond(rxCond), .txReq(txReq),
    .statReq(statReq), .srcEn(srcEn), .levelStrap(levelStrap),
    .baseWe(baseWe), .baseData(baseData), .iack(iack), .ackLevel(ackLevel),
    .chainIn(chainIn), .irqLines(irqLines), .vectorOut(vectorOut),
    .ackOut(ackOut), .chainOut(chainOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // returns {found, code}
  function automatic logic [4:0] expWin();
    for (int ch = 0; ch < 4; ch++) begin
      if (rxReq[ch] && srcEn[ch*3]) begin
        if (|rxCond[ch*4 +: 4]) return {1'b1, 4'(ch*4)};
        return {1'b1, 4'(ch*4+1)};
      end
      if (txReq[ch] && srcEn[ch*3+1])   return {1'b1, 4'(ch*4+2)};
      if (statReq[ch] && srcEn[ch*3+2]) return {1'b1, 4'(ch*4+3)};
    end
    return 5'd0;
  endfunction

  function automatic logic [6:0] expIrq();
    logic [4:0] w = expWin();
    if (w[4] && levelStrap != 0) return 7'(1) << (levelStrap - 1);
    return 7'd0;
  endfunction

  task automatic checkIrq(input string tag);
    logic [6:0] e = expIrq();
    check(irqLines == e, tag, irqLines, e);
  endtask

  // full acknowledge cycle; inputs already settled one cycle
  task automatic ackCycle(input logic [2:0] lvl, input bit scramble);
    logic [4:0] w = expWin();
    bit grant = w[4] && levelStrap != 0 && lvl == levelStrap;
    logic [7:0] ev = {modelBase, w[3:0]};
    logic [6:0] irqBefore = expIrq();
    ackLevel = lvl;
    iack     = 1'b1;
    chainIn  = 1'($urandom);
    step();
    if (grant) begin
      check(ackOut == 1'b1, "R7 ack", ackOut, 1);
      check(vectorOut == ev, "R5 R4 R3 vector", vectorOut, ev);
      check(chainOut == 1'b0, "R7 chainOut", chainOut, 0);
      check(irqLines == irqBefore, "R9 irq kept", irqLines, irqBefore);
    end else begin
      check(ackOut == 1'b0, "R8 no ack", ackOut, 0);
      check(chainOut == chainIn, "R8 pass", chainOut, chainIn);
    end
    if (scramble) begin
      rxReq = 4'($urandom); txReq = 4'($urandom); statReq = 4'($urandom);
      rxCond = 16'($urandom); srcEn = 12'($urandom);
    end
    chainIn = ~chainIn;
    step();
    if (grant) begin
      check(vectorOut == ev, "R6 vector frozen", vectorOut, ev);
      check(ackOut == 1'b1, "R7 ack held", ackOut, 1);
    end else begin
      check(chainOut == chainIn, "R8 pass follows", chainOut, chainIn);
    end
    iack = 1'b0;
    step();
    check(ackOut == 1'b0, "R7 ack drops", ackOut, 0);
    check(vectorOut == 8'd0, "R7 vector clears", vectorOut, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step();
    check(irqLines == 0 && ackOut == 0 && vectorOut == 0 && chainOut == 0,
          "R1 reset outputs", {irqLines, ackOut, chainOut}, 0);
    rstN = 1'b1;
    step();

    // R3: all disabled
    rxReq = 4'hF; txReq = 4'hF; statReq = 4'hF; srcEn = '0; levelStrap = 3'd5;
    step();
    checkIrq("R3 disabled no irq");
    ackCycle(3'd5, 1'b0);

    // R4: ch0 status beats ch1 receive
    rxReq = 4'b0010; txReq = 0; statReq = 4'b0001;
    srcEn = 12'b000_000_000_000; srcEn[2] = 1'b1; srcEn[3] = 1'b1;
    step();
    checkIrq("R2 R4 irq");
    ackCycle(3'd5, 1'b0);

    // R5: special vs plain receive on channel 2
    rxReq = 4'b0100; statReq = 0; srcEn = 12'hFFF; rxCond = 16'h0800;
    step();
    ackCycle(3'd5, 1'b1);
    rxReq = 4'b0100; txReq = 0; statReq = 0; srcEn = 12'hFFF; rxCond = 16'h0000;
    step();
    ackCycle(3'd5, 1'b0);

    // R10: base write
    baseWe = 1'b1; baseData = 4'hA; step(); baseWe = 1'b0; modelBase = 4'hA;
    ackCycle(3'd5, 1'b0);

    // R2: strap 0 never requests
    levelStrap = 3'd0; step();
    checkIrq("R2 strap zero");
    ackCycle(3'd0, 1'b0);

    // R8: mismatch and nothing pending
    levelStrap = 3'd3; step();
    ackCycle(3'd4, 1'b0);
    rxReq = 0; txReq = 0; statReq = 0; step();
    checkIrq("R2 nothing pending");
    ackCycle(3'd3, 1'b0);

    for (int it = 0; it < 200; it++) begin
      rxReq = 4'($urandom); txReq = 4'($urandom); statReq = 4'($urandom);
      rxCond = ($urandom % 2) ? 16'($urandom) : 16'd0;
      srcEn = 12'($urandom);
      levelStrap = 3'($urandom % 8);
      if ($urandom % 8 == 0) begin
        baseWe = 1'b1; baseData = 4'($urandom); modelBase = baseData;
      end
      step();
      baseWe = 1'b0;
      step();
      checkIrq("R2 random irq");
      ackCycle(($urandom % 3 == 0) ? 3'($urandom) : levelStrap, ($urandom % 2) == 1);
    end

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule